// File: doc/BRIEF.md
# Nested Interrupt Controller with Exceptions

This controller gathers a set of request sources, the lowest-indexed of which are software exceptions and the rest hardware interrupts. Each source has a pending latch, a mask bit and a vector register. On each cycle the controller selects the pending, unmasked source with the highest priority. If the in-service state allows it, the controller takes that source. A take raises a one-cycle `take` pulse, puts the source's vector on `vec`, and marks the source as in service. An exception take also tells the pipeline to discard the instructions it holds. An interrupt take tells the pipeline to let those instructions finish.

Software sets up the block through a simple write port. Through that port it writes the mask, a control word and the vector registers. The control word turns nested operation on or off and picks edge or level sensing for four programmable request lines. Every other source has its sensing fixed by a parameter. A `ret_in` pulse marks the end of a handler and clears the in-service bit of the highest-priority active source.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `take`, `abort_pipe` and `drain_pipe` are low. All mask bits are 0, so every source is disabled. Nothing is in service, nested mode is off and the four programmable lines use edge sensing.
- R2: The write port decodes three kinds of address. Address 0 is the mask, where bit i set to 1 enables source i. Address 1 is the control word, where bit 0 set to 1 selects nested mode and bits 4:1 select level sensing (1) or edge sensing (0) for sources NEXC to NEXC+3. Address 2+i is the vector register of source i.
- R3: When a request input rises, the latch is set at the first clock edge. The `take` pulse appears at the second clock edge and lasts one cycle. During that cycle `vec` holds the vector register of the taken source.
- R4: A take of a source with index below NEXC (an exception) raises `abort_pipe` and leaves `drain_pipe` low. A take of any other source raises `drain_pipe` and leaves `abort_pipe` low. Both outputs are low when `take` is low.
- R5: Among pending unmasked sources, the one with the lowest index is taken first.
- R6: In nested mode, a pending source is taken while others are in service only if its index is lower than that of every in-service source.
- R7: In non-nested mode, no source is taken while any source is in service.
- R8: A `ret_in` pulse clears the in-service bit of the lowest-indexed active source and leaves the other in-service bits unchanged.
- R9: An edge-sensitive latch is set by a rising input, even while that source is masked. It stays set until the source is taken, and then it clears.
- R10: A level-sensitive latch follows its input every cycle. A source held high is taken again after its return. A high pulse that ends while the source is masked leaves nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Request inputs; index 0 has the highest priority, indices below NEXC are exceptions |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| ret_in | input | 1 | Return-from-handler pulse |
| take | output | 1 | One-cycle pulse when a source is taken |
| vec | output | DW | Vector of the source taken |
| abort_pipe | output | 1 | Discard pipeline contents (exception take) |
| drain_pipe | output | 1 | Let pipeline contents complete (interrupt take) |

## Verification
Preemption depends on the order of events in time. The hard part is to set up an in-service state and then raise a second request against it. The bench first takes one source, then pulses another one, and does this for every ordered pair of edge sources in both nesting modes. It compares the take count with an expectation worked out from the two indices. The return-ordering rule is checked with two nested sources in service. After one return, the bench raises a probe source whose index lies between the two. That probe is taken only if the return cleared the higher-priority source.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int NEXC = 2,
  parameter int DW = 16,
  parameter int AW = 4,
  parameter logic [NSRC-1:0] LVL_FIXED = 8'h80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            ret_in,
  output logic            take,
  output logic [DW-1:0]   vec,
  output logic            abort_pipe,
  output logic            drain_pipe
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] mask_q, prev_q, lat_q, isr_q, lvl, pend, gmask, rmask;
  logic [DW-1:0]   vecs [NSRC];
  logic            nest_q, pvalid, avalid, grant;
  logic [3:0]      psel_q;
  logic [IW-1:0]   pidx, aidx;

  always_comb begin
    lvl = LVL_FIXED;
    lvl[NEXC +: 4] = psel_q;
    for (int i = 0; i < NEXC; i++) lvl[i] = 1'b0;
  end

  assign pend = lat_q & mask_q;

  always_comb begin
    pidx = '0; pvalid = 1'b0;
    aidx = '0; avalid = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i])  begin pidx = IW'(i); pvalid = 1'b1; end
      if (isr_q[i]) begin aidx = IW'(i); avalid = 1'b1; end
    end
  end

  assign grant = pvalid && (!avalid || (nest_q && pidx < aidx));

  always_comb begin
    gmask = '0;
    rmask = '0;
    if (grant) gmask[pidx] = 1'b1;
    if (ret_in && avalid) rmask[aidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      nest_q <= 1'b0;
      psel_q <= '0;
      for (int i = 0; i < NSRC; i++) vecs[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(0)) mask_q <= wr_data[NSRC-1:0];
      else if (wr_addr == AW'(1)) begin
        nest_q <= wr_data[0];
        psel_q <= wr_data[4:1];
      end else if (int'(wr_addr) - 2 < NSRC) vecs[int'(wr_addr) - 2] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q <= '0;
      isr_q <= '0;
      take <= 1'b0;
      vec <= '0;
      abort_pipe <= 1'b0;
      drain_pipe <= 1'b0;
    end else begin
      prev_q <= src_in;
      for (int i = 0; i < NSRC; i++)
        lat_q[i] <= lvl[i] ? src_in[i]
                           : ((lat_q[i] & ~gmask[i]) | (src_in[i] & ~prev_q[i]));
      isr_q <= (isr_q & ~rmask) | gmask;
      take <= grant;
      if (grant) vec <= vecs[pidx];
      abort_pipe <= grant && (int'(pidx) < NEXC);
      drain_pipe <= grant && (int'(pidx) >= NEXC);
    end
  end

  p_pipe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (abort_pipe ^ drain_pipe));
  p_pipe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (!abort_pipe && !drain_pipe));
  p_inserv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> isr_q != '0);
  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($past(nest_q) || $past(isr_q) == '0));
  p_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_in && isr_q != '0 && !grant) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, ret_in = 0;
  logic [NSRC-1:0] src_in = '0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0, vec, lastvec;
  logic take, abort_pipe, drain_pipe;
  int ncmp = 0, nerr = 0, ntake = 0;
  bit done = 0;

  nest_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ret_in(ret_in), .take(take), .vec(vec),
    .abort_pipe(abort_pipe), .drain_pipe(drain_pipe));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] vv(int i);
    return 16'hA000 + 16'(i * 37);
  endfunction

  function automatic bit is_lvl(int i, logic [3:0] ps);
    if (i == 7) return 1;
    if (i >= 2 && i <= 5) return ps[i-2];
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    ncmp++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    if (take) begin ntake++; lastvec = vec; end
  endtask

  task automatic window(int n);
    ntake = 0;
    repeat (n) tick();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
    tick();
    wr_en = 0;
  endtask

  task automatic ret();
    ret_in = 1; tick(); ret_in = 0;
  endtask

  task automatic pulse(int i);
    src_in[i] = 1; tick(); src_in[i] = 0;
  endtask

  task automatic do_reset();
    src_in = '0; ret_in = 0; wr_en = 0; rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
  endtask

  task automatic setup(bit nest, logic [3:0] ps, int mask);
    for (int i = 0; i < NSRC; i++) wr(2 + i, vv(i));
    wr(0, mask);
    wr(1, {ps, nest});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nerr++; ncmp++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end

  initial begin
    do_reset();
    tick();
    chk(take == 0 && abort_pipe == 0 && drain_pipe == 0, "R1 outputs idle", {take, abort_pipe, drain_pipe}, 0);
    pulse(6);
    window(4);
    chk(ntake == 0, "R1 mask cleared", ntake, 0);

    for (int nest = 0; nest < 2; nest++)
      for (int cfg = 0; cfg < 2; cfg++)
        for (int i = 0; i < NSRC; i++) begin
          logic [3:0] ps;
          bit lv;
          ps = cfg ? 4'hF : 4'h0;
          lv = is_lvl(i, ps);
          do_reset();
          setup(nest[0], ps, 8'hFF);
          src_in[i] = 1;
          tick();
          chk(take == 0, "R3 no take after first edge", take, 0);
          if (!lv) src_in[i] = 0;
          tick();
          chk(take == 1 && vec == vv(i), "R3 take and vector", vec, vv(i));
          chk(abort_pipe == (i < 2) && drain_pipe == (i >= 2), "R4 pipeline control",
              {abort_pipe, drain_pipe}, (i < 2) ? 2 : 1);
          window(3);
          chk(ntake == 0, "R9 R10 no retake while in service", ntake, 0);
          src_in[i] = 0;
          tick(); tick();
          ret();
          window(4);
          chk(ntake == 0, "R9 R10 latch empty after take", ntake, 0);
        end

    for (int nest = 0; nest < 2; nest++)
      for (int i = 0; i < 7; i++)
        for (int j = i + 1; j < 7; j++) begin
          do_reset();
          setup(nest[0], 4'h0, 8'hFF);
          src_in[i] = 1; src_in[j] = 1;
          tick();
          src_in = '0;
          window(4);
          chk(ntake == 1 && lastvec == vv(i), "R5 lowest index first", lastvec, vv(i));
          ret();
          window(4);
          chk(ntake == 1 && lastvec == vv(j), "R9 loser stays latched", lastvec, vv(j));
          ret();
        end

    for (int nest = 0; nest < 2; nest++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++) begin
          int e;
          if (a == b) continue;
          do_reset();
          setup(nest[0], 4'h0, 8'hFF);
          pulse(a);
          window(4);
          ntake = 0;
          pulse(b);
          repeat (3) tick();
          e = (nest == 1 && b < a) ? 1 : 0;
          chk(ntake == e, nest ? "R6 nested preemption" : "R7 blocked while in service", ntake, e);
          if (e == 0) begin
            ret();
            window(4);
            chk(ntake == 1 && lastvec == vv(b), "R7 taken after return", lastvec, vv(b));
          end
        end

    do_reset();
    setup(1'b1, 4'h0, 8'hFF);
    pulse(5); window(4);
    pulse(2); window(4);
    chk(ntake == 1 && lastvec == vv(2), "R6 preempt 2 over 5", lastvec, vv(2));
    ret();
    pulse(3); window(4);
    chk(ntake == 1 && lastvec == vv(3), "R8 return cleared highest", ntake, 1);

    do_reset();
    setup(1'b0, 4'h0, 8'hEF);
    pulse(4); window(4);
    chk(ntake == 0, "R2 masked source not taken", ntake, 0);
    wr(0, 8'hFF);
    window(4);
    chk(ntake == 1 && lastvec == vv(4), "R9 latch held while masked", lastvec, vv(4));

    for (int cfg = 0; cfg < 2; cfg++) begin
      do_reset();
      setup(1'b0, cfg ? 4'b0010 : 4'b0000, 8'hF7);
      src_in[3] = 1; tick(); tick();
      src_in[3] = 0; tick(); tick();
      wr(0, 8'hFF);
      window(4);
      chk(ntake == (cfg ? 0 : 1), cfg ? "R10 level latch follows input" : "R9 edge latch kept",
          ntake, cfg ? 0 : 1);
    end

    for (int ln = 2; ln <= 5; ln++)
      for (int cfg = 0; cfg < 2; cfg++) begin
        do_reset();
        setup(1'b1, cfg ? 4'(1 << (ln - 2)) : 4'h0, 8'hFF);
        src_in[ln] = 1;
        window(4);
        chk(ntake == 1, "R3 held source taken", ntake, 1);
        ret();
        window(4);
        chk(ntake == (cfg ? 1 : 0), cfg ? "R10 level retaken after return" : "R9 edge not retaken",
            ntake, cfg ? 1 : 0);
        src_in[ln] = 0;
      end

    do_reset();
    setup(1'b0, 4'h0, 8'hFF);
    wr(8, 16'h5A5A);
    pulse(6); window(4);
    chk(ntake == 1 && lastvec == 16'h5A5A, "R2 vector rewrite", lastvec, 16'h5A5A);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule